// File: doc/BRIEF.md
# Saturating Signed Arithmetic Unit

This unit adds, subtracts or multiplies two signed two's-complement operands of a parameterised width. A result that does not fit is clamped to the nearest end of the signed range; it never wraps. Each operation arrives with a qualifying strobe and a two-bit operation code. One clock later the unit presents a registered result of the same width. Two flags come with it and show whether the upper or the lower limit was applied.

Longer expressions are built outside the unit by feeding a result back in as an operand. Because every step clamps, the grouping of the terms changes the answer, and the caller picks the order. A cycle without the strobe leaves the last result and flags in place.

Top module: `sat_alu`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), out_valid, result, sat_hi and sat_lo are all zero.
- R2: out_valid is high in the cycle after a cycle with in_valid high, and low in the cycle after a cycle with in_valid low.
- R3: op_sel 2'b00 adds the operands. A sum above 2^(W-1)-1 yields 2^(W-1)-1 and a sum below -2^(W-1) yields -2^(W-1). For W=8: 64+69 gives 127, 0x77+0x99 gives 0x10, and 0x80+0xFF gives 0x80.
- R4: op_sel 2'b01 subtracts operand B from operand A with the same clamping. For W=8: -127-5 gives -128 (0x80), 0-(-128) gives 127, and 70-25 gives 45.
- R5: op_sel 2'b10 forms the full 2W-bit signed product and clamps it to the W-bit signed range. For W=8: 3*0x51 gives 127, -128*-128 gives 127, -16*9 gives -128, and -128*1 gives -128 with no flag.
- R6: op_sel 2'b11 returns operand A unchanged, and both flags are low.
- R7: sat_hi is high exactly when the upper limit was substituted, and sat_lo exactly when the lower limit was substituted. Both are never high together. A result that lands exactly on a limit without overflow (100+27=127) raises neither flag.
- R8: In a cycle without in_valid, result, sat_hi and sat_lo keep their previous values.
- R9: Chained evaluation clamps at each step. (64+70)-25 gives 102, while 64+(70-25) gives 109.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and op_sel are valid this cycle |
| op_sel | input | 2 | 00 add, 01 subtract, 10 multiply, 11 pass A |
| opnd_a | input | W | Signed operand A |
| opnd_b | input | W | Signed operand B |
| out_valid | output | 1 | Result register was loaded in the previous cycle |
| result | output | W | Clamped signed result |
| sat_hi | output | 1 | Result was clamped to the upper limit |
| sat_lo | output | 1 | Result was clamped to the lower limit |

## Verification
Clamping and an exact result on a limit can both produce the same output value, so only the flags tell them apart. The bench pairs operands that overflow to 127 or -128 with operands that reach 127 or -128 exactly, such as 100+27 and -128*1. It then judges the flag pair as well as the value against a model worked out from the signed range. Holding and updating also meet in one cycle when the strobe drops straight after a clamped result, so the bench checks that the stale flags persist unchanged in that cycle.

// File: rtl/sat_alu_pkg.sv
`timescale 1ns/1ps
package sat_alu_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_MUL  = 2'b10,
        OP_PASS = 2'b11
    } op_e;
endpackage

// File: rtl/sat_clamp.sv
`timescale 1ns/1ps
// Clamp a wide signed value into the W-bit signed range.
module sat_clamp #(
    parameter int IW = 9,
    parameter int W  = 8
) (
    input  logic signed [IW-1:0] val,
    output logic        [W-1:0]  res,
    output logic                 hi,
    output logic                 lo
);
    localparam int EXT = IW - W + 1;
    localparam logic signed [IW-1:0] TOP = {{EXT{1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [IW-1:0] BOT = {{EXT{1'b1}}, {(W-1){1'b0}}};

    always_comb begin
        hi = (val > TOP);
        lo = (val < BOT);
        if (hi)
            res = TOP[W-1:0];
        else if (lo)
            res = BOT[W-1:0];
        else
            res = val[W-1:0];
    end
endmodule

// File: rtl/sat_addsub.sv
`timescale 1ns/1ps
// Add or subtract with one guard bit, then clamp.
module sat_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         hi,
    output logic         lo
);
    logic signed [W:0] ext_a, ext_b, ext_sum;

    always_comb begin
        ext_a   = {a[W-1], a};
        ext_b   = {b[W-1], b};
        ext_sum = sub ? (ext_a - ext_b) : (ext_a + ext_b);
    end

    sat_clamp #(.IW(W + 1), .W(W)) clamp_i (
        .val (ext_sum),
        .res (res),
        .hi  (hi),
        .lo  (lo)
    );
endmodule

// File: rtl/sat_mul.sv
`timescale 1ns/1ps
// Full-width signed product, then clamp.
module sat_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         hi,
    output logic         lo
);
    localparam int PW = 2 * W;
    logic signed [PW-1:0] prod;

    always_comb begin
        prod = PW'($signed(a)) * PW'($signed(b));
    end

    sat_clamp #(.IW(PW), .W(W)) clamp_i (
        .val (prod),
        .res (res),
        .hi  (hi),
        .lo  (lo)
    );
endmodule

// File: rtl/sat_alu.sv
`timescale 1ns/1ps
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         sat_hi,
    output logic         sat_lo
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         hi;
        logic         lo;
    } state_t;

    state_t st_d, st_q;
    op_e    op;

    logic [W-1:0] as_res, mul_res;
    logic         as_hi, as_lo, mul_hi, mul_lo;

    assign op = op_e'(op_sel);

    sat_addsub #(.W(W)) addsub_i (
        .a   (opnd_a),
        .b   (opnd_b),
        .sub (op == OP_SUB),
        .res (as_res),
        .hi  (as_hi),
        .lo  (as_lo)
    );

    sat_mul #(.W(W)) mul_i (
        .a   (opnd_a),
        .b   (opnd_b),
        .res (mul_res),
        .hi  (mul_hi),
        .lo  (mul_lo)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            unique case (op)
                OP_ADD, OP_SUB: begin
                    st_d.res = as_res;
                    st_d.hi  = as_hi;
                    st_d.lo  = as_lo;
                end
                OP_MUL: begin
                    st_d.res = mul_res;
                    st_d.hi  = mul_hi;
                    st_d.lo  = mul_lo;
                end
                default: begin
                    st_d.res = opnd_a;
                    st_d.hi  = 1'b0;
                    st_d.lo  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign sat_hi    = st_q.hi;
    assign sat_lo    = st_q.lo;

    // Independent wide reference sum/difference for the checks below
    logic signed [W:0] chk_sum, chk_dif;
    assign chk_sum = $signed({opnd_a[W-1], opnd_a}) + $signed({opnd_b[W-1], opnd_b});
    assign chk_dif = $signed({opnd_a[W-1], opnd_a}) - $signed({opnd_b[W-1], opnd_b});

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    add_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b00 && chk_sum > $signed({1'b0, MAXV}))
        |=> (sat_hi && result == MAXV));
    // R4
    sub_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b01 && chk_dif < $signed({1'b1, MINV}))
        |=> (sat_lo && result == MINV));
    // R6
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b11)
        |=> (result == $past(opnd_a) && !sat_hi && !sat_lo));
    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sat_hi && sat_lo));
    // R7
    hi_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_hi |-> result == MAXV);
    // R7
    lo_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_lo |-> result == MINV);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(sat_hi) && $stable(sat_lo)));
endmodule

// File: tb/sat_alu_tb_top.sv
`timescale 1ns/1ps
module sat_alu_tb_top;
    localparam int W = 8;
    localparam int NV = 15;

    // vector = {op[1:0], a[7:0], b[7:0], expected[7:0], hi, lo}
    localparam logic [27:0] VEC [NV] = '{
        {2'b00, 8'h40, 8'h45, 8'h7F, 1'b1, 1'b0},  // R3 64+69
        {2'b00, 8'h77, 8'h99, 8'h10, 1'b0, 1'b0},  // R3 no overflow
        {2'b00, 8'h64, 8'h1B, 8'h7F, 1'b0, 1'b0},  // R7 exact limit
        {2'b00, 8'h80, 8'hFF, 8'h80, 1'b0, 1'b1},  // R3 low clamp
        {2'b01, 8'h81, 8'h05, 8'h80, 1'b0, 1'b1},  // R4 -127-5
        {2'b01, 8'h00, 8'h80, 8'h7F, 1'b1, 1'b0},  // R4 0-(-128)
        {2'b01, 8'h46, 8'h19, 8'h2D, 1'b0, 1'b0},  // R4 70-25
        {2'b10, 8'h03, 8'h51, 8'h7F, 1'b1, 1'b0},  // R5 3*81
        {2'b10, 8'h04, 8'h42, 8'h7F, 1'b1, 1'b0},  // R5 4*66
        {2'b10, 8'h80, 8'h80, 8'h7F, 1'b1, 1'b0},  // R5 -128*-128
        {2'b10, 8'h80, 8'h01, 8'h80, 1'b0, 1'b0},  // R5 exact min
        {2'b10, 8'hF0, 8'h09, 8'h80, 1'b0, 1'b1},  // R5 -16*9
        {2'b10, 8'hFB, 8'h07, 8'hDD, 1'b0, 1'b0},  // R5 -5*7
        {2'b11, 8'h80, 8'h7F, 8'h80, 1'b0, 1'b0},  // R6 pass
        {2'b11, 8'h5A, 8'h01, 8'h5A, 1'b0, 1'b0}   // R6 pass
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         out_valid;
    logic [W-1:0] result;
    logic         sat_hi, sat_lo;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sat_alu #(.W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .out_valid (out_valid),
        .result    (result),
        .sat_hi    (sat_hi),
        .sat_lo    (sat_lo)
    );

    // got/exp packed as {out_valid, result, sat_hi, sat_lo}
    task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got vld=%0b res=%02h hi=%0b lo=%0b, expected vld=%0b res=%02h hi=%0b lo=%0b",
                     tag, got[10], got[9:2], got[1], got[0], exp[10], exp[9:2], exp[1], exp[0]);
        end
    endtask

    // Called just after a falling edge; returns just after the next falling edge.
    task automatic issue(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        in_valid = 1'b1;
        op_sel   = op;
        opnd_a   = a;
        opnd_b   = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", {out_valid, result, sat_hi, sat_lo}, 11'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            string tag;
            v = VEC[i];
            case (v[27:26])
                2'b00:   tag = $sformatf("R3/R7/R2 vec %0d", i);
                2'b01:   tag = $sformatf("R4/R7/R2 vec %0d", i);
                2'b10:   tag = $sformatf("R5/R7/R2 vec %0d", i);
                default: tag = $sformatf("R6/R2 vec %0d", i);
            endcase
            issue(v[27:26], v[25:18], v[17:10]);
            check(tag, {out_valid, result, sat_hi, sat_lo}, {1'b1, v[9:0]});
        end

        // R8: hold after a clamped result, strobe dropped
        issue(2'b10, 8'h03, 8'h51);
        in_valid = 1'b0;
        opnd_a   = 8'h11;
        op_sel   = 2'b11;
        @(negedge clk);
        check("R8 hold after clamp", {out_valid, result, sat_hi, sat_lo}, {1'b0, 8'h7F, 1'b1, 1'b0});
        @(negedge clk);
        check("R8 hold second cycle", {out_valid, result, sat_hi, sat_lo}, {1'b0, 8'h7F, 1'b1, 1'b0});

        // R9: (64+70)-25 = 102
        issue(2'b00, 8'd64, 8'd70);
        check("R9 first sum clamps", {out_valid, result, sat_hi, sat_lo}, {1'b1, 8'h7F, 1'b1, 1'b0});
        issue(2'b01, result, 8'd25);
        check("R9 (64+70)-25", {out_valid, result, sat_hi, sat_lo}, {1'b1, 8'd102, 1'b0, 1'b0});
        // R9: 64+(70-25) = 109
        issue(2'b01, 8'd70, 8'd25);
        issue(2'b00, 8'd64, result);
        check("R9 64+(70-25)", {out_valid, result, sat_hi, sat_lo}, {1'b1, 8'd109, 1'b0, 1'b0});

        // R1: asynchronous reset mid-run clears a clamped state
        issue(2'b00, 8'h80, 8'h80);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1 async reset", {out_valid, result, sat_hi, sat_lo}, 11'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: idle after reset keeps out_valid low
        @(negedge clk);
        check("R2 idle", {out_valid, result, sat_hi, sat_lo}, 11'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule